// File: doc/BRIEF.md
# Salted Branch Target Buffer

This block is a direct-mapped branch target buffer for an instruction fetch stage. In every cycle a fetch address may be presented. One cycle later the block returns a hit flag and, on a hit, the predicted target of the branch at that address. When the pipeline resolves a branch, it presents the branch address and its real target on an update port, and the block writes that pair into the selected entry.

The entry is selected by a hash rather than a plain address slice. A low slice of the address is XORed with a higher slice of the address that has first been masked by a per-context salt. The salt is loaded on a context-switch strobe, and the same strobe empties the table. As a result, which pairs of branches share an entry changes with every salt. A run-time mode bit makes each lookup also compare a tag taken from the upper address bits. In that mode a foreign branch that lands on an occupied entry is reported as a miss, together with a one-cycle alias pulse, instead of being given the other branch's target.

Top module: `salted_btb`

## Requirements
- R1: After reset every entry is invalid, and `pred_hit` and `alias_pulse` are 0.
- R2: All results are registered. A lookup presented in cycle N shows on the outputs after the clock edge that ends cycle N. In a cycle with `fetch_vld` low, the next `pred_hit` and `alias_pulse` are both 0.
- R3: After an update of address A with target T, a lookup of A returns `pred_hit`=1 and `pred_target`=T. A later update to the same entry replaces it, so the last write wins. With `upd_vld` low, the update port writes nothing.
- R4: The entry index is `lo ^ (hi & salt)`, where `lo` = address bits [5:2], `hi` = address bits [9:6], and `salt` is the loaded 4-bit salt. With the defaults, address bits 10 and above never take part in the index.
- R5: In untagged mode (`tag_en`=0), a lookup that reaches a valid entry hits, whatever address wrote that entry, and `alias_pulse` stays 0.
- R6: In tagged mode (`tag_en`=1), the tag is address bits [13:6]. A lookup that reaches a valid entry whose stored tag differs returns a miss and raises `alias_pulse` for exactly that one result cycle.
- R7: In tagged mode, a lookup whose tag matches the stored tag hits, even if the two addresses differ in bits above bit 13.
- R8: A lookup and an update to the same index in the same cycle behave as if the update had already been written. The new target is forwarded, and in tagged mode the comparison uses the update's tag.
- R9: In a cycle with `ctx_switch` high, `ctx_salt` becomes the salt for all later cycles and every entry is invalidated. A lookup in that cycle misses without an alias pulse, and an update in that cycle is dropped.
- R10: The salt changes which addresses collide. With salt 0xF, addresses 0x040 and 0x004 share an entry. With salt 0x0 they use different entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tag_en | input | 1 | 1 selects tagged lookups |
| fetch_vld | input | 1 | A lookup is requested this cycle |
| fetch_pc | input | ADDR_W | Fetch address to look up |
| upd_vld | input | 1 | A resolved branch is written this cycle |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Target of the resolved branch |
| ctx_switch | input | 1 | Loads the salt and empties the table |
| ctx_salt | input | IDX_W | Salt for the new context |
| pred_hit | output | 1 | Registered hit flag |
| pred_target | output | ADDR_W | Registered predicted target, valid when `pred_hit` is 1 |
| alias_pulse | output | 1 | Registered one-cycle alias report |

## Verification
Every result of this block arrives exactly one clock edge after the cycle in which its lookup, update and strobe inputs were applied. There is one register stage and no other latency. The driver applies the inputs for one cycle on a falling edge and computes the expected result from its own table model. It then queues that result, stamped with the current cycle number. The monitor takes a queued item only once the cycle count has passed the item's stamp, which is the falling edge after the edge that registers the result. It compares the flags, and it compares the target whenever a hit is expected. State changes from an update or a context switch take effect in the model only after the expected result for that same cycle has been computed, which matches the forwarding and strobe rules.

// File: rtl/salted_btb_pkg.sv
// Shared types for the salted branch target buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package salted_btb_pkg;

    // Outcome of one lookup before it is registered
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_ALIAS = 2'd3
    } lookup_e;

endpackage

// File: rtl/btb_index_hash.sv
// Index and tag former: index = lo ^ (hi & salt), tag = bits above the low slice.
// Assumes ADDR_W covers IDX_LSB + IDX_W + max(IDX_W, TAG_W) bits.
module btb_index_hash #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IDX_W-1:0]  salt,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);
    localparam int HI_LSB = IDX_LSB + IDX_W;

    logic [IDX_W-1:0] lo_slice;
    logic [IDX_W-1:0] hi_slice;
    logic             unused_pc_bits;

    // Slice the address and mix the salt into the index
    always_comb begin
        lo_slice = pc[IDX_LSB +: IDX_W];
        hi_slice = pc[HI_LSB +: IDX_W];
        idx      = lo_slice ^ (hi_slice & salt);
        tag      = pc[HI_LSB +: TAG_W];
    end

    assign unused_pc_bits = ^pc;

endmodule

// File: rtl/btb_store.sv
// Entry storage: per-entry valid bit, tag and target, one write and one read port.
// Assumes clear has priority over a write in the same cycle; read is combinational.
module btb_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [TGT_W-1:0] wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    output logic [TGT_W-1:0] rd_tgt
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [TGT_W-1:0]   tgt_q [ENTRIES];

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_entry
            // Valid bit: reset and clear empty it, a write to this entry fills it
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    valid_q[e] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                    valid_q[e] <= 1'b1;
                end
            end

            // Payload: tag and target follow every accepted write
            always_ff @(posedge clk) begin
                if (!clr && wr_en && (wr_idx == IDX_W'(e))) begin
                    tag_q[e] <= wr_tag;
                    tgt_q[e] <= wr_tgt;
                end
            end
        end
    endgenerate

    // Read port
    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_tag   = tag_q[rd_idx];
        rd_tgt   = tgt_q[rd_idx];
    end

endmodule

// File: rtl/btb_lookup.sv
// Lookup resolution with update forwarding and registered outputs.
// Assumes kill marks a context-switch cycle, in which every lookup misses.
module btb_lookup
    import salted_btb_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8,
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tag_en,
    input  logic             kill,
    input  logic             fetch_vld,
    input  logic [IDX_W-1:0] fetch_idx,
    input  logic [TAG_W-1:0] fetch_tag,
    input  logic             upd_vld,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] upd_tag,
    input  logic [TGT_W-1:0] upd_tgt,
    input  logic             rd_valid,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic [TGT_W-1:0] rd_tgt,
    output logic             pred_hit,
    output logic [TGT_W-1:0] pred_target,
    output logic             alias_pulse
);
    logic             fwd;
    logic             eff_valid;
    logic [TAG_W-1:0] eff_tag;
    logic [TGT_W-1:0] eff_tgt;
    lookup_e          outcome;

    // Choose the forwarded update or the stored entry, then classify
    always_comb begin
        fwd       = upd_vld && (upd_idx == fetch_idx);
        eff_valid = fwd ? 1'b1 : rd_valid;
        eff_tag   = fwd ? upd_tag : rd_tag;
        eff_tgt   = fwd ? upd_tgt : rd_tgt;
        if (!fetch_vld || kill) begin
            outcome = LK_NONE;
        end else if (!eff_valid) begin
            outcome = LK_MISS;
        end else if (!tag_en || (eff_tag == fetch_tag)) begin
            outcome = LK_HIT;
        end else begin
            outcome = LK_ALIAS;
        end
    end

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_hit    <= 1'b0;
            alias_pulse <= 1'b0;
            pred_target <= '0;
        end else begin
            pred_hit    <= (outcome == LK_HIT);
            alias_pulse <= (outcome == LK_ALIAS);
            if (outcome == LK_HIT) begin
                pred_target <= eff_tgt;
            end
        end
    end

endmodule

// File: rtl/salted_btb.sv
// Top: salted, optionally tagged, direct-mapped branch target buffer.
// Assumes one lookup and one update per cycle; ctx_switch has priority over updates.
module salted_btb #(
    parameter int ADDR_W  = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 4,
    parameter int TAG_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tag_en,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic              upd_vld,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              ctx_switch,
    input  logic [IDX_W-1:0]  ctx_salt,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    output logic              alias_pulse
);
    logic [IDX_W-1:0] salt_q;
    logic [IDX_W-1:0] f_idx, u_idx;
    logic [TAG_W-1:0] f_tag, u_tag;
    logic             rd_valid;
    logic [TAG_W-1:0] rd_tag;
    logic [ADDR_W-1:0] rd_tgt;
    logic             wr_en;

    // Salt register: loaded on each context switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            salt_q <= '0;
        end else if (ctx_switch) begin
            salt_q <= ctx_salt;
        end
    end

    assign wr_en = upd_vld && !ctx_switch;

    btb_index_hash #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    i_fetch_hash (.pc(fetch_pc), .salt(salt_q), .idx(f_idx), .tag(f_tag));

    btb_index_hash #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W))
    i_upd_hash (.pc(upd_pc), .salt(salt_q), .idx(u_idx), .tag(u_tag));

    btb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(ADDR_W)) i_store (
        .clk(clk), .rst_n(rst_n), .clr(ctx_switch),
        .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_tgt(upd_target),
        .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt)
    );

    btb_lookup #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(ADDR_W)) i_lookup (
        .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .kill(ctx_switch),
        .fetch_vld(fetch_vld), .fetch_idx(f_idx), .fetch_tag(f_tag),
        .upd_vld(upd_vld), .upd_idx(u_idx), .upd_tag(u_tag), .upd_tgt(upd_target),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
        .pred_hit(pred_hit), .pred_target(pred_target), .alias_pulse(alias_pulse)
    );

endmodule

// File: rtl/btb_checker.sv
// Port-level properties of salted_btb, bound into every instance.
// Assumes synchronous active-low reset on rst_n.
module btb_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tag_en,
    input logic              fetch_vld,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              upd_vld,
    input logic [ADDR_W-1:0] upd_pc,
    input logic [ADDR_W-1:0] upd_target,
    input logic              ctx_switch,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_target,
    input logic              alias_pulse
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (!pred_hit && !alias_pulse)); // R2

    AST_HIT_ALIAS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pred_hit && alias_pulse)); // R6

    AST_UNTAGGED_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_en |=> !alias_pulse); // R5

    AST_SWITCH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> (!pred_hit && !alias_pulse)); // R9

    AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_vld && upd_vld && !ctx_switch && (fetch_pc == upd_pc))
        |=> (pred_hit && (pred_target == $past(upd_target)))); // R8

endmodule

bind salted_btb btb_checker #(.ADDR_W(ADDR_W)) i_btb_checker (
    .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .fetch_vld(fetch_vld),
    .fetch_pc(fetch_pc), .upd_vld(upd_vld), .upd_pc(upd_pc),
    .upd_target(upd_target), .ctx_switch(ctx_switch), .pred_hit(pred_hit),
    .pred_target(pred_target), .alias_pulse(alias_pulse)
);

// File: tb/test_salted_btb.sv
// Scoreboard bench: driver pushes expected results, monitor pops and compares.
module test_salted_btb;
    localparam int AW = 32;
    localparam int IW = 4;
    localparam int TW = 8;
    localparam int NE = 1 << IW;

    typedef struct {
        int          stamp;
        bit          hit;
        bit [AW-1:0] tgt;
        bit          alias_;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tag_en = 1'b0;
    logic          fetch_vld = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          upd_vld = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic [AW-1:0] upd_target = '0;
    logic          ctx_switch = 1'b0;
    logic [IW-1:0] ctx_salt = '0;
    logic          pred_hit;
    logic [AW-1:0] pred_target;
    logic          alias_pulse;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;
    exp_t q[$];

    // Reference model state
    bit          m_v [NE];
    bit [TW-1:0] m_tag [NE];
    bit [AW-1:0] m_tgt [NE];
    bit [IW-1:0] m_salt = '0;

    salted_btb i_salted_btb (
        .clk(clk), .rst_n(rst_n), .tag_en(tag_en), .fetch_vld(fetch_vld),
        .fetch_pc(fetch_pc), .upd_vld(upd_vld), .upd_pc(upd_pc),
        .upd_target(upd_target), .ctx_switch(ctx_switch), .ctx_salt(ctx_salt),
        .pred_hit(pred_hit), .pred_target(pred_target), .alias_pulse(alias_pulse)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit [IW-1:0] m_idx(bit [AW-1:0] pc);
        return pc[5:2] ^ (pc[9:6] & m_salt);
    endfunction

    function automatic bit [TW-1:0] m_tg(bit [AW-1:0] pc);
        return pc[13:6];
    endfunction

    task automatic check(string req, string what, bit [AW-1:0] act, bit [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(bit fv, bit [AW-1:0] fpc, bit uv, bit [AW-1:0] upc,
                        bit [AW-1:0] utg, bit sw, bit [IW-1:0] slt, string req);
        exp_t        e;
        bit          ev;
        bit [TW-1:0] et;
        bit [AW-1:0] eg;
        bit [IW-1:0] fi;
        @(negedge clk);
        fetch_vld = fv; fetch_pc = fpc; upd_vld = uv; upd_pc = upc;
        upd_target = utg; ctx_switch = sw; ctx_salt = slt;
        e.stamp = cyc; e.req = req; e.hit = 0; e.alias_ = 0; e.tgt = '0;
        if (fv && !sw) begin
            fi = m_idx(fpc);
            if (uv && m_idx(upc) == fi) begin
                ev = 1; et = m_tg(upc); eg = utg;
            end else begin
                ev = m_v[fi]; et = m_tag[fi]; eg = m_tgt[fi];
            end
            if (ev && (!tag_en || et == m_tg(fpc))) begin
                e.hit = 1; e.tgt = eg;
            end else if (ev) begin
                e.alias_ = 1;
            end
        end
        q.push_back(e);
        if (sw) begin
            for (int i = 0; i < NE; i++) m_v[i] = 0;
            m_salt = slt;
        end else if (uv) begin
            m_v[m_idx(upc)] = 1; m_tag[m_idx(upc)] = m_tg(upc); m_tgt[m_idx(upc)] = utg;
        end
    endtask

    task automatic look(bit [AW-1:0] pc, string req);
        step(1, pc, 0, '0, '0, 0, '0, req);
    endtask

    task automatic upd(bit [AW-1:0] pc, bit [AW-1:0] tg, string req);
        step(0, '0, 1, pc, tg, 0, '0, req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, '0, '0, 0, '0, "R2");
    endtask

    // Monitor: compare each result once its register edge has passed
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].stamp < cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "hit", AW'(pred_hit), AW'(e.hit));
            check(e.req, "alias", AW'(alias_pulse), AW'(e.alias_));
            if (e.hit) check(e.req, "target", pred_target, e.tgt);
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "hit after reset", AW'(pred_hit), '0);
        check("R1", "alias after reset", AW'(alias_pulse), '0);
        for (int i = 0; i < NE; i++) look(AW'(i * 4), "R1");
        // R3 basic fill, overwrite, and gated update
        upd(32'h100, 32'hA000, "R3");
        look(32'h100, "R3");
        upd(32'h100, 32'hA100, "R3");
        look(32'h100, "R3");
        step(0, '0, 0, 32'h100, 32'hDEAD, 0, '0, "R3");
        look(32'h100, "R3");
        idle(2);
        // R4 R5 untagged aliasing with bits 10 and up ignored
        look(32'h500, "R5");
        look(32'h7FFF_FC00 | 32'h100, "R4");
        // R6 R7 tagged mode
        @(negedge clk); tag_en = 1'b1;
        look(32'h500, "R6");
        look(32'h4100, "R7");
        look(32'h100, "R7");
        // R8 forwarding, matching and mismatching tags
        step(1, 32'h200, 1, 32'h200, 32'hB000, 0, '0, "R8");
        step(1, 32'h600, 1, 32'h200, 32'hB100, 0, '0, "R8");
        look(32'h200, "R8");
        // R9 context switch: lookup misses, update dropped, table cleared
        step(1, 32'h200, 1, 32'h300, 32'hC000, 1, 4'hF, "R9");
        look(32'h200, "R9");
        look(32'h300, "R9");
        look(32'h100, "R9");
        // R10 salt-dependent collisions, untagged
        @(negedge clk); tag_en = 1'b0;
        upd(32'h040, 32'hD000, "R10");
        look(32'h004, "R10");
        step(0, '0, 0, '0, '0, 1, 4'h0, "R9");
        upd(32'h040, 32'hD100, "R10");
        look(32'h004, "R10");
        look(32'h040, "R10");
        // Mixed traffic over a small address pool
        for (int k = 0; k < 3000; k++) begin
            bit [AW-1:0] a, b;
            a = {18'($urandom_range(0, 3)), 12'($urandom_range(0, 63)) << 4, 2'b00};
            b = {18'($urandom_range(0, 3)), 12'($urandom_range(0, 63)) << 4, 2'b00};
            if (k % 500 == 0) begin
                @(negedge clk); tag_en = ~tag_en;
            end
            step($urandom_range(0, 3) != 0, a, $urandom_range(0, 1) == 1, b,
                 $urandom, $urandom_range(0, 199) == 0, IW'($urandom), "R8");
        end
        idle(3);
        done = 1;
        finish_run();
    end

endmodule